// File: doc/BRIEF.md
# High-Voltage Charging Request Decoder

This block turns the voltage requests that a portable device signals on the USB data lines into a target output voltage for an adaptive charger. It runs once high-voltage negotiation has been agreed. Each data line arrives already sorted by an analog comparator stage into one of three levels: ground, about 0.6 V, or about 3.3 V. The block decodes the pair of levels into one of three fixed output settings or into a continuous mode. In continuous mode, single pulses on either line move the output up or down in 200 mV steps.

Two codes leave the block. The first is the target output voltage in 200 mV units. The second is the reference code for the voltage loop in 40 mV units. Because the output divider ratio is 5, the two codes have the same value once the reference has settled. When the target goes up, the reference follows at once. When the target goes down, the reference is lowered one code at a time, so the output capacitor has time to discharge without the loop overshooting. Mode changes have a debounce and a blanking interval after them. Step pulses have their own, shorter debounce. All timing is given in clock cycles through parameters.

Top module: `hv_request_decoder`

## Requirements
- R1: Line codes are 0 = ground, 1 = 0.6 V, 2 = 3.3 V; code 3 is invalid. The settled request (D+, D−) = (1, 0) gives target 25 (5 V). The request (2, 1) gives target 45 (9 V). The request (1, 1) gives target 60 (12 V). The request (1, 2) selects continuous mode.
- R2: A new request takes effect only after it has been present unchanged for MODE_DB_CYC cycles. A request that is shorter than this leaves the target unchanged.
- R3: For BLANK_CYC cycles after an accepted mode change, no further mode change and no step is accepted.
- R4: The reserved pair (2, 2) and any pair that contains code 3 keep the current mode and target.
- R5: Continuous mode can be entered from any fixed mode, and the target keeps its value on entry. While in continuous mode, only a settled 5 V request ends the mode. The 9 V and 12 V patterns have no effect as mode requests.
- R6: In continuous mode, a D+ pulse at code 2 that lasts at least PULSE_DB_CYC cycles raises the target by 1 when the pulse ends. A D− pulse at code 1 of the same minimum length lowers the target by 1. Shorter pulses are ignored.
- R7: The target stays between 18 (3.6 V) and 60 (12 V). A step that would leave this range is ignored.
- R8: The reference code is in 40 mV units and settles to the target value. When the target rises, the reference takes the new value on the next cycle.
- R9: When the target falls, the reference drops by one code every RAMP_STEP_CYC cycles until it equals the target.
- R10: Reset, or hv_active low, sets the target to 25 and fixed 5 V mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hv_active | input | 1 | High while high-voltage negotiation is in force; low means the device has detached |
| dp_lvl | input | 2 | Classified D+ level (0 ground, 1 0.6 V, 2 3.3 V) |
| dn_lvl | input | 2 | Classified D− level (same coding) |
| target_code | output | CODE_W | Target output voltage in 200 mV units |
| ref_code | output | CODE_W | Voltage-loop reference in 40 mV units |
| cont_mode | output | 1 | High while continuous mode is active |

## Verification
The bench builds the block with MODE_DB_CYC=16, BLANK_CYC=24, PULSE_DB_CYC=4 and RAMP_STEP_CYC=3 in place of the millisecond values. With these settings a glitch shorter than the debounce, a request that lands inside the blanking window, a full ramp from 12 V down to 5 V, and a walk of continuous steps from one limit to the other each take tens to hundreds of cycles. Because the blanking window is longer than the mode debounce, the bench can hold a valid request past its debounce and still see it blocked.

// File: rtl/hvr_pkg.sv
// Shared types and code values for the high-voltage request decoder.
// Assumes a 200 mV target step and a divider ratio of 5, so reference
// codes in 40 mV units have the same value as target codes.
package hvr_pkg;
    localparam int STEP_MV  = 200;
    localparam int CODE_5V  = 5000 / STEP_MV;
    localparam int CODE_9V  = 9000 / STEP_MV;
    localparam int CODE_12V = 12000 / STEP_MV;
    localparam int CODE_MIN = 3600 / STEP_MV;
    localparam int CODE_MAX = CODE_12V;

    typedef enum logic [1:0] {
        LV_GND  = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_BAD  = 2'd3
    } line_lvl_e;

    typedef enum logic [2:0] {
        RQ_5V, RQ_9V, RQ_12V, RQ_STEP, RQ_KEEP
    } req_e;

    typedef enum logic [1:0] {
        MD_5V, MD_9V, MD_12V, MD_STEP
    } mode_e;
endpackage

// File: rtl/hvr_line_decode.sv
// Combinational decode of the classified D+/D- levels into a request.
// Assumes the levels are already synchronised to clk.
module hvr_line_decode
    import hvr_pkg::*;
(
    input  logic [1:0] dp_lvl,
    input  logic [1:0] dn_lvl,
    output req_e       req
);
    // map the level pair onto a request; every other pair keeps state
    always_comb begin
        req = RQ_KEEP;
        if (dp_lvl == LV_LOW  && dn_lvl == LV_GND)  req = RQ_5V;
        if (dp_lvl == LV_HIGH && dn_lvl == LV_LOW)  req = RQ_9V;
        if (dp_lvl == LV_LOW  && dn_lvl == LV_LOW)  req = RQ_12V;
        if (dp_lvl == LV_LOW  && dn_lvl == LV_HIGH) req = RQ_STEP;
    end
endmodule

// File: rtl/hvr_pulse_qual.sv
// Measures how long a condition stays high. When the condition ends after
// lasting at least MIN_CYC cycles, it issues a one-cycle strobe.
// Assumes the condition input is synchronous to clk.
module hvr_pulse_qual #(
    parameter int MIN_CYC = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cond,
    output logic strobe
);
    localparam int RUN_W = $clog2(MIN_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MIN_CYC);

    logic [RUN_W-1:0] run_q;
    logic             cond_q;

    // count the length of the high run and flag a qualified falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q  <= '0;
            cond_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            cond_q <= cond;
            strobe <= cond_q && !cond && (run_q == RUN_SAT);
            if (!cond)
                run_q <= '0;
            else if (run_q != RUN_SAT)
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/hvr_ref_ramp.sv
// Reference follower. It jumps up to the target on the next cycle and
// steps down one code every STEP_CYC cycles while above the target.
// Assumes the target moves slowly compared with the clock.
module hvr_ref_ramp #(
    parameter int CODE_W     = 7,
    parameter int STEP_CYC   = 57000,
    parameter int RESET_CODE = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] ref_out
);
    localparam int DIV_W = $clog2(STEP_CYC + 1);
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(STEP_CYC - 1);

    logic [DIV_W-1:0] div_q;

    // rise at once, fall one code per STEP_CYC cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_out <= CODE_W'(RESET_CODE);
            div_q   <= '0;
        end else if (target >= ref_out) begin
            ref_out <= target;
            div_q   <= '0;
        end else if (div_q == DIV_END) begin
            ref_out <= ref_out - 1'b1;
            div_q   <= '0;
        end else begin
            div_q   <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/hv_request_decoder.sv
// Top of the high-voltage request decoder. It debounces line-level
// requests, holds the mode state, applies continuous steps within the
// limits and drives the softly ramped reference code.
// Assumes dp_lvl/dn_lvl are synchronised and hv_active gates operation.
module hv_request_decoder
    import hvr_pkg::*;
#(
    parameter int MODE_DB_CYC   = 2_000_000,
    parameter int BLANK_CYC     = 3_000_000,
    parameter int PULSE_DB_CYC  = 7_500,
    parameter int RAMP_STEP_CYC = 57_000,
    parameter int CODE_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_active,
    input  logic [1:0]        dp_lvl,
    input  logic [1:0]        dn_lvl,
    output logic [CODE_W-1:0] target_code,
    output logic [CODE_W-1:0] ref_code,
    output logic              cont_mode
);
    localparam int MDB_W = $clog2(MODE_DB_CYC + 1);
    localparam int BLK_W = $clog2(BLANK_CYC + 1);
    localparam logic [MDB_W-1:0]  MDB_SAT = MDB_W'(MODE_DB_CYC);
    localparam logic [BLK_W-1:0]  BLK_LEN = BLK_W'(BLANK_CYC);
    localparam logic [CODE_W-1:0] C_5V  = CODE_W'(CODE_5V);
    localparam logic [CODE_W-1:0] C_9V  = CODE_W'(CODE_9V);
    localparam logic [CODE_W-1:0] C_12V = CODE_W'(CODE_12V);
    localparam logic [CODE_W-1:0] C_MIN = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] C_MAX = CODE_W'(CODE_MAX);

    req_e             req;
    req_e             cand_q;
    logic [MDB_W-1:0] stab_q;
    logic [BLK_W-1:0] blank_q;
    mode_e            mode_q;
    mode_e            want_mode;
    logic             settled, accept;
    logic [1:0]       step_cond, step_stb;

    hvr_line_decode dec_i (.dp_lvl(dp_lvl), .dn_lvl(dn_lvl), .req(req));

    // index 0 qualifies D+ high pulses (up), index 1 D- low pulses (down)
    assign step_cond[0] = (dp_lvl == LV_HIGH);
    assign step_cond[1] = (dn_lvl == LV_LOW);

    for (genvar g = 0; g < 2; g++) begin : g_pulse
        hvr_pulse_qual #(.MIN_CYC(PULSE_DB_CYC)) qual_i (
            .clk(clk), .rst_n(rst_n), .clr(!hv_active),
            .cond(step_cond[g]), .strobe(step_stb[g])
        );
    end

    // mode that the settled candidate asks for
    always_comb begin
        unique case (cand_q)
            RQ_9V:   want_mode = MD_9V;
            RQ_12V:  want_mode = MD_12V;
            RQ_STEP: want_mode = MD_STEP;
            default: want_mode = MD_5V;
        endcase
    end

    assign settled = (req == cand_q) && (stab_q == MDB_SAT);
    assign accept  = settled && (blank_q == '0) && (cand_q != RQ_KEEP) &&
                     (want_mode != mode_q) &&
                     ((mode_q != MD_STEP) || (cand_q == RQ_5V));

    // request debounce, blanking, mode state and target updates
    always_ff @(posedge clk) begin
        if (!rst_n || !hv_active) begin
            cand_q      <= RQ_KEEP;
            stab_q      <= '0;
            blank_q     <= '0;
            mode_q      <= MD_5V;
            target_code <= C_5V;
        end else begin
            if (req != cand_q) begin
                cand_q <= req;
                stab_q <= '0;
            end else if (stab_q != MDB_SAT) begin
                stab_q <= stab_q + 1'b1;
            end

            if (accept) begin
                mode_q  <= want_mode;
                blank_q <= BLK_LEN;
                unique case (want_mode)
                    MD_9V:   target_code <= C_9V;
                    MD_12V:  target_code <= C_12V;
                    MD_STEP: target_code <= target_code;
                    default: target_code <= C_5V;
                endcase
            end else begin
                if (blank_q != '0)
                    blank_q <= blank_q - 1'b1;
                if (mode_q == MD_STEP && blank_q == '0) begin
                    if (step_stb[0] && !step_stb[1] && target_code < C_MAX)
                        target_code <= target_code + 1'b1;
                    else if (step_stb[1] && !step_stb[0] && target_code > C_MIN)
                        target_code <= target_code - 1'b1;
                end
            end
        end
    end

    assign cont_mode = (mode_q == MD_STEP);

    hvr_ref_ramp #(
        .CODE_W(CODE_W), .STEP_CYC(RAMP_STEP_CYC), .RESET_CODE(CODE_5V)
    ) ramp_i (
        .clk(clk), .rst_n(rst_n), .target(target_code), .ref_out(ref_code)
    );
endmodule

// File: rtl/hv_request_decoder_chk.sv
// Assertion checker bound to hv_request_decoder. It observes only the
// top-level ports. Assumes synchronous active-low reset.
module hv_request_decoder_chk
    import hvr_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_active,
    input logic [CODE_W-1:0] target_code,
    input logic [CODE_W-1:0] ref_code,
    input logic              cont_mode
);
    // R7
    target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_code >= CODE_W'(CODE_MIN)) && (target_code <= CODE_W'(CODE_MAX)));

    // R10
    detach_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_active |=> (target_code == CODE_W'(CODE_5V)) && !cont_mode);

    // R5
    entry_keeps_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cont_mode) |-> $stable(target_code));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_mode && $past(cont_mode) && $past(hv_active)) |->
        ((target_code <= $past(target_code) + 1'b1) &&
         (target_code + 1'b1 >= $past(target_code))));

    // R9
    ramp_slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code < $past(ref_code)) |-> (ref_code + 1'b1 == $past(ref_code)));

    // R8
    rise_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code > $past(ref_code)) |-> (ref_code == $past(target_code)));
endmodule

bind hv_request_decoder hv_request_decoder_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .hv_active(hv_active),
    .target_code(target_code), .ref_code(ref_code), .cont_mode(cont_mode)
);

// File: tb/hv_request_decoder_tb_top.sv
// Directed bench for hv_request_decoder: one task per scenario.
module hv_request_decoder_tb_top;
    localparam int MDB = 16, BLK = 24, PDB = 4, RMP = 3, CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_active = 1'b1;
    logic [1:0]    dp_lvl = 2'd1;
    logic [1:0]    dn_lvl = 2'd0;
    logic [CW-1:0] target_code, ref_code;
    logic          cont_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hv_request_decoder #(
        .MODE_DB_CYC(MDB), .BLANK_CYC(BLK), .PULSE_DB_CYC(PDB),
        .RAMP_STEP_CYC(RMP), .CODE_W(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hv_active(hv_active),
        .dp_lvl(dp_lvl), .dn_lvl(dn_lvl),
        .target_code(target_code), .ref_code(ref_code), .cont_mode(cont_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic [1:0] p, input logic [1:0] n);
        dp_lvl = p;
        dn_lvl = n;
    endtask

    task automatic pulse_up(input int len);
        dp_lvl = 2'd2; cyc(len); dp_lvl = 2'd1; cyc(5);
    endtask

    task automatic pulse_dn(input int len);
        dn_lvl = 2'd1; cyc(len); dn_lvl = 2'd2; cyc(5);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
        chk("R10 reset target", target_code, 25);
        chk("R10 reset ref", ref_code, 25);
        chk("R10 reset mode", cont_mode, 0);
    endtask

    task automatic t_glitch;
        lines(2, 1); cyc(8); lines(1, 0); cyc(40);
        chk("R2 short request ignored", target_code, 25);
    endtask

    task automatic t_fixed;
        lines(2, 1); cyc(MDB - 4);
        chk("R2 before debounce", target_code, 25);
        cyc(10);
        chk("R1 9V code", target_code, 45);
        cyc(2);
        chk("R8 ref follows rise", ref_code, 45);
        cyc(40);
        lines(1, 1); cyc(30);
        chk("R1 12V code", target_code, 60);
        chk("R8 ref at 12V", ref_code, 60);
    endtask

    task automatic t_blank;
        lines(1, 0);
        for (int i = 0; i < 40; i++) begin
            if (target_code != 60) break;
            cyc(1);
        end
        chk("R1 5V code", target_code, 25);
        lines(2, 1); cyc(18);
        chk("R3 request in blanking held", target_code, 25);
        chk("R9 ramp in progress", (ref_code > 25 && ref_code < 60), 1);
        cyc(15);
        chk("R3 request after blanking", target_code, 45);
        cyc(40);
        chk("R9 ramp settled", ref_code, 45);
    endtask

    task automatic t_reserved;
        lines(2, 2); cyc(40);
        chk("R4 reserved keeps target", target_code, 45);
        lines(3, 3); cyc(40);
        chk("R4 invalid keeps target", target_code, 45);
        chk("R4 invalid keeps mode", cont_mode, 0);
    endtask

    task automatic t_cont;
        lines(1, 2); cyc(30);
        chk("R5 entry mode", cont_mode, 1);
        chk("R5 entry keeps target", target_code, 45);
        cyc(30);
        pulse_up(6);
        chk("R6 up pulse", target_code, 46);
        pulse_up(2);
        chk("R6 short pulse ignored", target_code, 46);
        pulse_dn(6);
        chk("R6 down pulse", target_code, 45);
        pulse_dn(30);
        chk("R5 12V pattern no exit", cont_mode, 1);
        chk("R6 long down pulse", target_code, 44);
    endtask

    task automatic t_limits;
        for (int i = 0; i < 17; i++) pulse_up(6);
        chk("R7 upper limit", target_code, 60);
        for (int i = 0; i < 43; i++) pulse_dn(6);
        chk("R7 lower limit", target_code, 18);
        cyc(10);
        chk("R9 ref tracks down", ref_code, 18);
    endtask

    task automatic t_exit;
        lines(1, 0); cyc(30);
        chk("R5 exit to 5V mode", cont_mode, 0);
        chk("R5 exit target", target_code, 25);
        chk("R8 ref rise on exit", ref_code, 25);
    endtask

    task automatic t_detach;
        lines(1, 2); cyc(30); cyc(30);
        pulse_up(6); pulse_up(6); pulse_up(6);
        chk("R6 steps before detach", target_code, 28);
        hv_active = 1'b0; cyc(1); hv_active = 1'b1;
        chk("R10 detach target", target_code, 25);
        chk("R10 detach mode", cont_mode, 0);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_fixed();
        t_blank();
        t_reserved();
        t_cont();
        t_limits();
        t_exit();
        t_detach();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule